// File: doc/BRIEF.md
# Four-Bit Function-Select ALU Slice

This block is a four-bit arithmetic and logic slice. It takes two operands, a four-bit function code and a mode bit. In logic mode it returns any of the sixteen bitwise functions of two variables. In arithmetic mode it returns one of sixteen add or subtract style functions, with a carry input that adds one when asserted. The carry input and the carry output are both active low. The slice also drives two group signals for an external lookahead unit: group propagate and group generate, both active low. An all-ones flag is high whenever every result bit is one.

Every arithmetic function is the sum of two derived words, called first term X and second term Y, plus the carry. Both terms are formed bit by bit from A, B and the function code, and one lookahead carry network adds them. The outputs are registered. A result appears on the ports one clock after its inputs are sampled. A synchronous active-high reset clears the outputs.

Top module: `alu_fn_slice`

## Requirements
- R1: The outputs are registered and show the function of the inputs sampled at the previous rising clock edge. While `rst` is high at a rising edge, the outputs become result=0, carry_out_n=1, grp_prop_n=1, grp_gen_n=1 and all_ones=0.
- R2: With logic_mode=1, each result bit is a bitwise function of its A and B bits, selected by fsel as follows: 0000 NOT A, 0001 NOR, 0010 (NOT A) AND B, 0011 constant 0, 0100 NAND, 0101 NOT B, 0110 XOR, 0111 A AND (NOT B), 1000 (NOT A) OR B, 1001 XNOR, 1010 B, 1011 AND, 1100 constant 1, 1101 A OR (NOT B), 1110 OR, 1111 A. carry_in_n has no effect on the result.
- R3: With logic_mode=0, result = (X + Y + c) mod 16, where c=1 when carry_in_n is low. The terms (X, Y) for each fsel are: 0000 (A,0), 0001 (A|B,0), 0010 (A|~B,0), 0011 (15,0), 0100 (A,A&~B), 0101 (A|B,A&~B), 0110 (A,~B), 0111 (A&~B,15), 1000 (A,A&B), 1001 (A,B), 1010 (A|~B,A&B), 1011 (A&B,15), 1100 (A,A), 1101 (A|B,A), 1110 (A|~B,A), 1111 (A,15).
- R4: In arithmetic mode, fsel=1001 yields A+B and fsel=0110 yields A-B-1. With carry_in_n low, these become A+B+1 and A-B.
- R5: carry_out_n is low exactly when X+Y+c is 16 or more. This holds in both modes. For fsel=0110 it is low when no borrow occurs and high on underflow.
- R6: grp_prop_n is low exactly when X+Y equals 15. grp_gen_n is low exactly when X+Y is 16 or more. Neither signal depends on carry_in_n or logic_mode, and the two are never low together.
- R7: all_ones is high exactly when every result bit is 1. For fsel=0110 in arithmetic mode with carry_in_n high, it is high exactly when A equals B.
- R8: In arithmetic mode with carry_in_n high, fsel=1100 yields A shifted one place toward the MSB (A+A mod 16), fsel=0000 yields A, and fsel=1111 yields A-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opa | input | 4 | Operand A |
| opb | input | 4 | Operand B |
| fsel | input | 4 | Function code |
| logic_mode | input | 1 | 1 selects bitwise logic, 0 selects arithmetic |
| carry_in_n | input | 1 | Carry input, active low |
| result | output | 4 | Registered function result |
| carry_out_n | output | 1 | Registered carry output, active low |
| grp_prop_n | output | 1 | Registered group propagate, active low |
| grp_gen_n | output | 1 | Registered group generate, active low |
| all_ones | output | 1 | Registered flag, high when result is all ones |

## Verification
The only state in the slice is the output register. Any fault in the term encoder, the carry network or the result stage therefore reaches the ports one clock after the offending inputs. Every combination of function code, mode, carry and operands is applied once against a table model. A wrong term bit, a misrouted carry or a swapped group output therefore shows as a mismatch on the very next sample. A separate check drives new inputs and samples the outputs before the next edge. It catches a path that bypasses the register, because the old result must still be visible at that point.

// File: rtl/alu_fn_pkg.sv
`timescale 1ns/1ps
package alu_fn_pkg;
  localparam int FSEL_W = 4;
  typedef logic [FSEL_W-1:0] fsel_t;

  localparam fsel_t FN_PASS = 4'b0000;
  localparam fsel_t FN_ZERO = 4'b0011;
  localparam fsel_t FN_SUB  = 4'b0110;
  localparam fsel_t FN_ADD  = 4'b1001;
  localparam fsel_t FN_DBL  = 4'b1100;
  localparam fsel_t FN_DEC  = 4'b1111;

  typedef struct packed {
    logic prop;
    logic gen;
  } grp_t;
endpackage

// File: rtl/alu_bit_terms.sv
`timescale 1ns/1ps
module alu_bit_terms
  import alu_fn_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  fsel_t        fsel,
  output logic [W-1:0] term_x,
  output logic [W-1:0] term_y
);
  // term_x: A OR'd with B or NOT B under fsel[1:0]
  // term_y: A gated by NOT B or B under fsel[3:2]; always a subset of term_x
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign term_x[i] = opa[i] | (opb[i] & fsel[0]) | (~opb[i] & fsel[1]);
    assign term_y[i] = (opa[i] & ~opb[i] & fsel[2]) | (opa[i] & opb[i] & fsel[3]);
  end
endmodule

// File: rtl/alu_lookahead.sv
`timescale 1ns/1ps
module alu_lookahead
  import alu_fn_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] term_x,
  input  logic [W-1:0] term_y,
  input  logic         cin,
  output logic [W:0]   carry,
  output grp_t         grp
);
  logic [W-1:0] bp;
  logic [W-1:0] bg;

  assign bp = term_x ^ term_y;
  assign bg = term_x & term_y;

  // Flat sum-of-products carries: each carry built from generate and
  // propagate terms of all lower bits, not from the previous carry.
  always_comb begin
    logic run;
    logic acc;
    carry    = '0;
    carry[0] = cin;
    grp      = '0;
    for (int i = 0; i < W; i++) begin
      run = 1'b1;
      acc = 1'b0;
      for (int j = i; j >= 0; j--) begin
        acc = acc | (bg[j] & run);
        run = run & bp[j];
      end
      carry[i+1] = acc | (run & cin);
      if (i == W - 1) begin
        grp.gen  = acc;
        grp.prop = run;
      end
    end
  end
endmodule

// File: rtl/alu_result.sv
`timescale 1ns/1ps
module alu_result #(
  parameter int W = 4
) (
  input  logic [W-1:0] term_x,
  input  logic [W-1:0] term_y,
  input  logic [W-1:0] carry,
  input  logic         logic_mode,
  output logic [W-1:0] f,
  output logic         ones
);
  logic [W-1:0] half;
  assign half = term_x ^ term_y;

  for (genvar i = 0; i < W; i++) begin : g_out
    // logic mode suppresses every carry and inverts the half sum
    assign f[i] = logic_mode ? ~half[i] : (half[i] ^ carry[i]);
  end

  assign ones = &f;
endmodule

// File: rtl/alu_fn_slice.sv
`timescale 1ns/1ps
module alu_fn_slice
  import alu_fn_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [3:0]   fsel,
  input  logic         logic_mode,
  input  logic         carry_in_n,
  output logic [W-1:0] result,
  output logic         carry_out_n,
  output logic         grp_prop_n,
  output logic         grp_gen_n,
  output logic         all_ones
);
  logic [W-1:0] tx;
  logic [W-1:0] ty;
  logic [W:0]   cy;
  grp_t         grp;
  logic [W-1:0] f_d;
  logic         ones_d;

  alu_bit_terms #(.W(W)) u_terms (
    .opa    (opa),
    .opb    (opb),
    .fsel   (fsel),
    .term_x (tx),
    .term_y (ty)
  );

  alu_lookahead #(.W(W)) u_cla (
    .term_x (tx),
    .term_y (ty),
    .cin    (~carry_in_n),
    .carry  (cy),
    .grp    (grp)
  );

  alu_result #(.W(W)) u_res (
    .term_x     (tx),
    .term_y     (ty),
    .carry      (cy[W-1:0]),
    .logic_mode (logic_mode),
    .f          (f_d),
    .ones       (ones_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result      <= '0;
      carry_out_n <= 1'b1;
      grp_prop_n  <= 1'b1;
      grp_gen_n   <= 1'b1;
      all_ones    <= 1'b0;
    end else begin
      result      <= f_d;
      carry_out_n <= ~cy[W];
      grp_prop_n  <= ~grp.prop;
      grp_gen_n   <= ~grp.gen;
      all_ones    <= ones_d;
    end
  end

  // R2
  const_one_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(logic_mode) && $past(fsel) == FN_DBL) |-> (result == '1 && all_ones));

  // R2
  const_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(logic_mode) && $past(fsel) == FN_ZERO) |-> (result == '0 && !all_ones));

  // R6
  pg_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!grp_prop_n && !grp_gen_n));

  // R5
  gen_carry_chk: assert property (@(posedge clk) disable iff (rst)
    !grp_gen_n |-> !carry_out_n);

  // R8
  pass_a_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(logic_mode) && $past(fsel) == FN_PASS && $past(carry_in_n))
      |-> (result == $past(opa)));
endmodule

// File: tb/sim_alu_fn_slice.sv
`timescale 1ns/1ps
module sim_alu_fn_slice;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opa = '0, opb = '0, fsel = '0;
  logic       logic_mode = 1'b0, carry_in_n = 1'b1;
  logic [3:0] result;
  logic       carry_out_n, grp_prop_n, grp_gen_n, all_ones;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  alu_fn_slice #(.W(4)) u0 (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .fsel(fsel),
    .logic_mode(logic_mode), .carry_in_n(carry_in_n),
    .result(result), .carry_out_n(carry_out_n), .grp_prop_n(grp_prop_n),
    .grp_gen_n(grp_gen_n), .all_ones(all_ones)
  );

  // {a, b, fsel, mode, cin_n, f, cout_n, p_n, g_n, ones}
  localparam int NV = 19;
  localparam logic [21:0] VEC [NV] = '{
    {4'd7,  4'd8,  4'b1001, 1'b0, 1'b1, 4'b1111, 1'b1, 1'b0, 1'b1, 1'b1},
    {4'd7,  4'd8,  4'b1001, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd9,  4'd9,  4'b1001, 1'b0, 1'b1, 4'b0010, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd5,  4'd5,  4'b0110, 1'b0, 1'b1, 4'b1111, 1'b1, 1'b0, 1'b1, 1'b1},
    {4'd5,  4'd5,  4'b0110, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd3,  4'd6,  4'b0110, 1'b0, 1'b0, 4'b1101, 1'b1, 1'b1, 1'b1, 1'b0},
    {4'd12, 4'd4,  4'b0110, 1'b0, 1'b0, 4'b1000, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd5,  4'd0,  4'b1100, 1'b0, 1'b1, 4'b1010, 1'b1, 1'b1, 1'b1, 1'b0},
    {4'd11, 4'd0,  4'b1100, 1'b0, 1'b1, 4'b0110, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd6,  4'd0,  4'b0000, 1'b0, 1'b1, 4'b0110, 1'b1, 1'b1, 1'b1, 1'b0},
    {4'd0,  4'd0,  4'b1111, 1'b0, 1'b1, 4'b1111, 1'b1, 1'b0, 1'b1, 1'b1},
    {4'd4,  4'd0,  4'b1111, 1'b0, 1'b1, 4'b0011, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd10, 4'd0,  4'b0000, 1'b1, 1'b1, 4'b0101, 1'b1, 1'b1, 1'b1, 1'b0},
    {4'd11, 4'd0,  4'b1100, 1'b1, 1'b0, 4'b1111, 1'b0, 1'b1, 1'b0, 1'b1},
    {4'd3,  4'd5,  4'b0011, 1'b1, 1'b1, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b0},
    {4'd12, 4'd10, 4'b0110, 1'b1, 1'b1, 4'b0110, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd12, 4'd10, 4'b1001, 1'b1, 1'b1, 4'b1001, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd6,  4'd3,  4'b1111, 1'b1, 1'b0, 4'b0110, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd10, 4'd0,  4'b0000, 1'b1, 1'b0, 4'b0101, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // Reference from the requirement tables: R2 logic, R3 terms
  function automatic logic [7:0] model(input logic [3:0] a, input logic [3:0] b,
                                       input logic [3:0] s, input logic m, input logic cn);
    logic [3:0] x, y, lf, f;
    logic [4:0] s5, t5;
    case (s)
      4'b0000: begin x = a;       y = 4'd0;    lf = ~a;       end
      4'b0001: begin x = a | b;   y = 4'd0;    lf = ~(a | b); end
      4'b0010: begin x = a | ~b;  y = 4'd0;    lf = ~a & b;   end
      4'b0011: begin x = 4'd15;   y = 4'd0;    lf = 4'd0;     end
      4'b0100: begin x = a;       y = a & ~b;  lf = ~(a & b); end
      4'b0101: begin x = a | b;   y = a & ~b;  lf = ~b;       end
      4'b0110: begin x = a;       y = ~b;      lf = a ^ b;    end
      4'b0111: begin x = a & ~b;  y = 4'd15;   lf = a & ~b;   end
      4'b1000: begin x = a;       y = a & b;   lf = ~a | b;   end
      4'b1001: begin x = a;       y = b;       lf = ~(a ^ b); end
      4'b1010: begin x = a | ~b;  y = a & b;   lf = b;        end
      4'b1011: begin x = a & b;   y = 4'd15;   lf = a & b;    end
      4'b1100: begin x = a;       y = a;       lf = 4'd15;    end
      4'b1101: begin x = a | b;   y = a;       lf = a | ~b;   end
      4'b1110: begin x = a | ~b;  y = a;       lf = a | b;    end
      default: begin x = a;       y = 4'd15;   lf = a;        end
    endcase
    s5 = {1'b0, x} + {1'b0, y};
    t5 = s5 + {4'd0, ~cn};
    f  = m ? lf : t5[3:0];
    return {f, ~t5[4], ~(s5 == 5'd15), ~(s5 >= 5'd16), &f};
  endfunction

  function automatic string ftag(input logic [3:0] s, input logic m);
    if (m) return "R2";
    if (s == 4'b1001 || s == 4'b0110) return "R4";
    if (s == 4'b1100 || s == 4'b0000 || s == 4'b1111) return "R8";
    return "R3";
  endfunction

  task automatic check_all(input logic [3:0] s, input logic m, input logic [7:0] e);
    chk(ftag(s, m), "result", {4'd0, result}, {4'd0, e[7:4]});
    chk("R5", "carry_out_n", {7'd0, carry_out_n}, {7'd0, e[3]});
    chk("R6", "grp_prop_n", {7'd0, grp_prop_n}, {7'd0, e[2]});
    chk("R6", "grp_gen_n", {7'd0, grp_gen_n}, {7'd0, e[1]});
    chk("R7", "all_ones", {7'd0, all_ones}, {7'd0, e[0]});
  endtask

  task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic [3:0] s,
                       input logic m, input logic cn);
    opa = a; opb = b; fsel = s; logic_mode = m; carry_in_n = cn;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state, with non-idle inputs applied
    @(negedge clk);
    opa = 4'd9; opb = 4'd9; fsel = 4'b1001; logic_mode = 1'b0; carry_in_n = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R1", "reset result", {4'd0, result}, 8'd0);
    chk("R1", "reset group/carry", {5'd0, carry_out_n, grp_prop_n, grp_gen_n}, 8'h07);
    chk("R1", "reset all_ones", {7'd0, all_ones}, 8'd0);
    rst = 1'b0;

    // Directed vector table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][21:18], VEC[i][17:14], VEC[i][13:10], VEC[i][9], VEC[i][8]);
      check_all(VEC[i][13:10], VEC[i][9], VEC[i][7:0]);
    end

    // R1 latency: new inputs must not reach the outputs before the edge
    apply(4'd7, 4'd8, 4'b1001, 1'b0, 1'b1);
    opa = 4'd9; opb = 4'd9; carry_in_n = 1'b1;
    #1;
    chk("R1", "output held before edge", {4'd0, result}, 8'h0f);
    @(posedge clk); @(negedge clk);
    chk("R1", "output after edge", {4'd0, result}, 8'h02);

    // R2 carry-in ignored in logic mode, every code and operand pair
    for (int s = 0; s < 16; s++) begin
      apply(4'b1100, 4'b1010, 4'(s), 1'b1, 1'b1);
      begin
        logic [3:0] r_hi;
        r_hi = result;
        apply(4'b1100, 4'b1010, 4'(s), 1'b1, 1'b0);
        chk("R2", "carry_in_n effect on logic result", {4'd0, result}, {4'd0, r_hi});
      end
    end

    // R7 equality with subtract and no carry
    apply(4'd13, 4'd13, 4'b0110, 1'b0, 1'b1);
    chk("R7", "equal operands flag", {7'd0, all_ones}, 8'd1);
    apply(4'd13, 4'd12, 4'b0110, 1'b0, 1'b1);
    chk("R7", "unequal operands flag", {7'd0, all_ones}, 8'd0);

    // Exhaustive sweep against the table model (R2..R8)
    for (int k = 0; k < 16384; k++) begin
      logic [3:0] a, b, s;
      logic m, cn;
      a = 4'(k); b = 4'(k >> 4); s = 4'(k >> 8); cn = k[12]; m = k[13];
      apply(a, b, s, m, cn);
      check_all(s, m, model(a, b, s, m, cn));
    end

    // R1 reset in mid-run
    opa = 4'd15; opb = 4'd15; fsel = 4'b1001; logic_mode = 1'b0; carry_in_n = 1'b0;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1", "mid-run reset result", {4'd0, result}, 8'd0);
    chk("R1", "mid-run reset group/carry", {5'd0, carry_out_n, grp_prop_n, grp_gen_n}, 8'h07);
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule